// File: doc/BRIEF.md
# Serial Memory Write-Protection and Status Controller

This block decodes the status-related commands of a serial memory slave on a mode-0 SPI link (MSB first) and owns the write protection of that memory. It holds a write-enable flag and a status byte. The status byte carries a pin-lock enable bit and a two-bit protected-region selector. Four one-byte commands are recognised: set enable (0x06), clear enable (0x04), read status (0x05) and write status (0x01, followed by a data byte). Commands take effect only when chip select is released after a whole number of bytes.

For the memory array, the block does not move any data. It drives a registered per-address permit that an array write path consults. It also accepts a one-cycle strobe from that path when an array write finishes, and the strobe drops the enable flag. The active-low protect pin can lock the status byte but never affects array permits. The SPI inputs are oversampled in the system clock domain.

Top module: `spi_wp_ctrl`

## Requirements
- R1: The enable flag (status bit 1) is set only by a complete 0x06 command, and it reads back as 1 afterwards.
- R2: A complete 0x04 command clears the enable flag.
- R3: For 0x05, the slave shifts the status byte out on MISO MSB first during the byte that follows the opcode, and it drives 0x00 in any further bytes.
- R4: A 0x01 command with a data byte is accepted only when the enable flag is 1 and either the protect pin is high or status bit 7 is 0. When accepted, data bit 7 goes to status bit 7 and data bits 3:2 go to status bits 3:2. Otherwise the status byte stays unchanged.
- R5: An accepted status write clears the enable flag, and a rejected one leaves the flag as it was.
- R6: Status bits 6, 5, 4 and 0 always read 0. Data bits 6, 5, 4, 1 and 0 of a status write have no effect.
- R7: A one-cycle pulse on arr_wr_done clears the enable flag.
- R8: wr_permit is 1 one clock after the address is presented, when the enable flag is 1 and the address lies outside the protected region. Status bits 3:2 select that region: 00 none, 01 the top quarter (top two address bits 11), 10 the top half (top address bit 1), 11 every address.
- R9: The protect pin has no effect on wr_permit.
- R10: No command takes effect in these cases, which leave the status byte and the flag unchanged:
  - chip select rises with a partial byte outstanding;
  - the opcode is unknown;
  - a 0x01 opcode arrives without its data byte.
- R11: After reset, the status byte reads 0x00, wr_permit is 0 and miso is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| wp_n | input | 1 | Active-low status lock pin |
| arr_addr | input | ADDR_W | Array address whose write permit is asked |
| arr_wr_done | input | 1 | Pulse: an array write has finished |
| wr_permit | output | 1 | Registered write permit for arr_addr |

## Verification
The bench attempts a status write with the flag clear, and with the pin low under both values of the lock bit. A design that ignored the flag would protect memory without any enable. A design that let the pin act alone would refuse a write the lock bit allows. It writes 0xFF to prove that the reserved bits and the flag bit cannot be forced. It also releases chip select mid-byte and sends a status-write opcode with no data byte. A design that fired on bit counts or on the opcode alone would change the status byte in these cases. Region edges at 0x0FFF/0x1000 and 0x17FF/0x1800 catch an off-by-one in the region decode. Pulling the pin low while the array permit is set catches a pin that leaks into the array path.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;

  localparam logic [7:0] OP_SET_EN = 8'h06;
  localparam logic [7:0] OP_CLR_EN = 8'h04;
  localparam logic [7:0] OP_RD_ST  = 8'h05;
  localparam logic [7:0] OP_WR_ST  = 8'h01;

  localparam int unsigned BYTE_CNT_W = 2;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] region;
    logic       wr_en;
  } wp_state_t;

  function automatic logic [7:0] status_byte(input wp_state_t s);
    return {s.lock_en, 3'b000, s.region, s.wr_en, 1'b0};
  endfunction

endpackage

// File: rtl/spi_wp_sync.sv
module spi_wp_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) r <= {STAGES{RST_VAL}};
        else     r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_wp_rx.sv
module spi_wp_rx
  import spi_wp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_s,
  input  logic                  cs_n_s,
  input  logic                  mosi_s,
  output logic                  sck_fall,
  output logic                  cmd_evt,
  output logic                  whole,
  output logic [2:0]            bit_cnt,
  output logic [BYTE_CNT_W-1:0] byte_cnt,
  output logic [7:0]            opcode,
  output logic [7:0]            data
);

  localparam logic [BYTE_CNT_W-1:0] BYTE_MAX = '1;

  logic       sck_q;
  logic       cs_n_q;
  logic [7:0] shift;
  logic       sck_rise;
  logic [7:0] next_byte;

  assign sck_rise  = sck_s & ~sck_q & ~cs_n_s;
  assign sck_fall  = ~sck_s & sck_q & ~cs_n_s;
  assign cmd_evt   = cs_n_s & ~cs_n_q;
  assign whole     = (bit_cnt == 3'd0);
  assign next_byte = {shift[6:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      cs_n_q   <= 1'b1;
      shift    <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      opcode   <= '0;
      data     <= '0;
    end else begin
      sck_q  <= sck_s;
      cs_n_q <= cs_n_s;
      if (cs_n_s) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end else if (sck_rise) begin
        shift   <= next_byte;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != BYTE_MAX) byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == '0)       opcode   <= next_byte;
          if (byte_cnt == 1)        data     <= next_byte;
        end
      end
    end
  end

endmodule

// File: rtl/spi_wp_status.sv
module spi_wp_status
  import spi_wp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_evt,
  input  logic                  whole,
  input  logic [BYTE_CNT_W-1:0] byte_cnt,
  input  logic [7:0]            opcode,
  input  logic [7:0]            data,
  input  logic                  wp_n,
  input  logic                  arr_wr_done,
  output wp_state_t             st
);

  logic       wr_ok;
  logic       valid_cmd;
  logic       unused_data;

  assign unused_data = ^{data[6:4], data[1:0]};
  assign valid_cmd   = cmd_evt & whole & (byte_cnt != '0);
  assign wr_ok       = st.wr_en & (wp_n | ~st.lock_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      if (arr_wr_done) st.wr_en <= 1'b0;
      if (valid_cmd) begin
        case (opcode)
          OP_SET_EN: st.wr_en <= 1'b1;
          OP_CLR_EN: st.wr_en <= 1'b0;
          OP_WR_ST: begin
            if (byte_cnt >= 2 && wr_ok) begin
              st.lock_en <= data[7];
              st.region  <= data[3:2];
              st.wr_en   <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_wp_tx.sv
module spi_wp_tx
  import spi_wp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n_s,
  input  logic                  sck_fall,
  input  logic [2:0]            bit_cnt,
  input  logic [BYTE_CNT_W-1:0] byte_cnt,
  input  logic [7:0]            opcode,
  input  logic [7:0]            status,
  output logic                  miso
);

  logic [7:0] out_sr;
  logic       load;

  assign load = (byte_cnt == 1) && (bit_cnt == 3'd0) && (opcode == OP_RD_ST);

  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      out_sr <= '0;
    end else if (sck_fall) begin
      if (load) out_sr <= status;
      else      out_sr <= {out_sr[6:0], 1'b0};
    end
  end

  assign miso = out_sr[7];

endmodule

// File: rtl/spi_wp_permit.sv
module spi_wp_permit #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        region,
  input  logic [ADDR_W-1:0] addr,
  output logic              permit
);

  localparam int unsigned TOP = ADDR_W - 1;

  logic       guarded;
  logic [1:0] top2;
  logic       unused_addr;

  assign top2        = addr[TOP -: 2];
  assign unused_addr = ^addr[TOP-2:0];

  always_comb begin
    case (region)
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = &top2;
      2'b10:   guarded = top2[1];
      default: guarded = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) permit <= 1'b0;
    else     permit <= wr_en & ~guarded;
  end

endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
  import spi_wp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              arr_wr_done,
  output logic              wr_permit
);

  logic [2:0]            pins_s;
  logic                  sck_fall;
  logic                  cmd_evt;
  logic                  whole;
  logic [2:0]            bit_cnt;
  logic [BYTE_CNT_W-1:0] byte_cnt;
  logic [7:0]            opcode;
  logic [7:0]            data;
  wp_state_t             st;
  logic                  wel;
  logic                  wpen;
  logic [1:0]            bp;

  assign wel  = st.wr_en;
  assign wpen = st.lock_en;
  assign bp   = st.region;

  spi_wp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk(clk), .rst(rst), .d({sck, cs_n, mosi}), .q(pins_s)
  );

  spi_wp_rx i_rx (
    .clk(clk), .rst(rst),
    .sck_s(pins_s[2]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[0]),
    .sck_fall(sck_fall), .cmd_evt(cmd_evt), .whole(whole),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .opcode(opcode), .data(data)
  );

  spi_wp_status i_status (
    .clk(clk), .rst(rst), .cmd_evt(cmd_evt), .whole(whole),
    .byte_cnt(byte_cnt), .opcode(opcode), .data(data),
    .wp_n(wp_n), .arr_wr_done(arr_wr_done), .st(st)
  );

  spi_wp_tx i_tx (
    .clk(clk), .rst(rst), .cs_n_s(pins_s[1]), .sck_fall(sck_fall),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .opcode(opcode),
    .status(status_byte(st)), .miso(miso)
  );

  spi_wp_permit #(.ADDR_W(ADDR_W)) i_permit (
    .clk(clk), .rst(rst), .wr_en(wel), .region(bp),
    .addr(arr_addr), .permit(wr_permit)
  );

endmodule

// File: rtl/spi_wp_ctrl_chk.sv
module spi_wp_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wp_n,
  input logic       arr_wr_done,
  input logic       cmd_evt,
  input logic       whole,
  input logic [7:0] opcode,
  input logic       wel,
  input logic       wpen,
  input logic [1:0] bp,
  input logic       wr_permit
);

  AST_WEL_ONLY_BY_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(cmd_evt && opcode == 8'h06));  // R1

  AST_PIN_LOCKS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && wpen) |=> ($stable(bp) && wpen));  // R4

  AST_STATUS_WRITE_DROPS_WEL: assert property (@(posedge clk) disable iff (rst)
    (!$stable(bp) || !$stable(wpen)) |-> !wel);  // R5

  AST_DONE_DROPS_WEL: assert property (@(posedge clk) disable iff (rst)
    (arr_wr_done && !cmd_evt) |=> !wel);  // R7

  AST_PERMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    wr_permit |-> $past(wel));  // R8

  AST_FULL_REGION_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    wr_permit |-> ($past(bp) != 2'b11));  // R8

  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cmd_evt && !whole && !arr_wr_done) |=> ($stable(wel) && $stable(bp) && $stable(wpen)));  // R10

endmodule

bind spi_wp_ctrl spi_wp_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .wp_n(wp_n), .arr_wr_done(arr_wr_done),
  .cmd_evt(cmd_evt), .whole(whole), .opcode(opcode),
  .wel(wel), .wpen(wpen), .bp(bp), .wr_permit(wr_permit)
);

// File: tb/test_spi_wp_ctrl.sv
module test_spi_wp_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HP         = 6;
  localparam int AW         = 13;
  localparam int NV         = 13;

  // {wp_n, opcode, data, bytes, expected status}
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 8'h01, 8'h8C, 2'd2, 8'h00},  // R4 no flag -> rejected
    {1'b1, 8'h06, 8'h00, 2'd1, 8'h02},  // R1
    {1'b1, 8'h01, 8'hFF, 2'd2, 8'h8C},  // R6 R5
    {1'b1, 8'h06, 8'h00, 2'd1, 8'h8E},  // R1
    {1'b0, 8'h01, 8'h00, 2'd2, 8'h8E},  // R4 pin low + lock -> rejected
    {1'b1, 8'h01, 8'h04, 2'd2, 8'h04},  // R4 pin high
    {1'b0, 8'h06, 8'h00, 2'd1, 8'h06},  // R1
    {1'b0, 8'h01, 8'h08, 2'd2, 8'h08},  // R4 pin low, lock clear
    {1'b1, 8'h06, 8'h00, 2'd1, 8'h0A},  // R1
    {1'b1, 8'h01, 8'h00, 2'd1, 8'h0A},  // R10 no data byte
    {1'b1, 8'h04, 8'h00, 2'd1, 8'h08},  // R2
    {1'b1, 8'h55, 8'h00, 2'd1, 8'h08},  // R10 unknown
    {1'b1, 8'h06, 8'h00, 2'd1, 8'h0A}   // R1
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sck = 1'b0;
  logic          cs_n = 1'b1;
  logic          mosi = 1'b0;
  logic          miso;
  logic          wp_n = 1'b1;
  logic [AW-1:0] arr_addr = '0;
  logic          arr_wr_done = 1'b0;
  logic          wr_permit;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_wp_ctrl #(.ADDR_W(AW)) i_spi_wp_ctrl (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .wp_n(wp_n), .arr_addr(arr_addr), .arr_wr_done(arr_wr_done),
    .wr_permit(wr_permit)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic spi_xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                          input int nb, input int extra,
                          output logic [7:0] q1, output logic [7:0] q2);
    logic [7:0] tx [3];
    tx = '{b0, b1, b2};
    q1 = '0;
    q2 = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = tx[k][i];
        repeat (HP) @(negedge clk);
        if (k == 1) q1[i] = miso;
        if (k == 2) q2[i] = miso;
        sck = 1'b1;
        repeat (HP) @(negedge clk);
        sck = 1'b0;
      end
    end
    for (int i = 0; i < extra; i++) begin
      mosi = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d1, d2;
    spi_xfer(op, 8'h00, 8'h00, 1, 0, d1, d2);
  endtask

  task automatic wr_status(input logic [7:0] v);
    logic [7:0] d1, d2;
    spi_xfer(8'h01, v, 8'h00, 2, 0, d1, d2);
  endtask

  task automatic rd_status(output logic [7:0] v);
    logic [7:0] d2;
    spi_xfer(8'h05, 8'h00, 8'h00, 2, 0, v, d2);
  endtask

  task automatic check_permit(input string tag, input logic [AW-1:0] a, input logic exp);
    arr_addr = a;
    repeat (3) @(negedge clk);
    check(tag, {7'd0, wr_permit}, {7'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, q1, q2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 permit after reset", {7'd0, wr_permit}, 8'h00);
    check("R11 miso after reset", {7'd0, miso}, 8'h00);
    rd_status(s);
    check("R11 status after reset", s, 8'h00);

    for (int v = 0; v < NV; v++) begin
      wp_n = VEC[v][26];
      spi_xfer(VEC[v][25:18], VEC[v][17:10], 8'h00, int'(VEC[v][9:8]), 0, q1, q2);
      wp_n = 1'b1;
      rd_status(s);
      check($sformatf("R1 R2 R4 R5 R6 R10 vector %0d", v), s, VEC[v][7:0]);
    end

    // region 10, flag set
    check_permit("R8 below half", 13'h0FFF, 1'b1);
    check_permit("R8 at half", 13'h1000, 1'b0);
    wp_n = 1'b0;
    check_permit("R9 pin low keeps permit", 13'h0FFF, 1'b1);
    wp_n = 1'b1;

    spi_xfer(8'h05, 8'h00, 8'h00, 3, 0, q1, q2);
    check("R3 status byte", q1, 8'h0A);
    check("R3 trailing byte", q2, 8'h00);

    @(negedge clk);
    arr_wr_done = 1'b1;
    @(negedge clk);
    arr_wr_done = 1'b0;
    rd_status(s);
    check("R7 done clears flag", s, 8'h08);
    check_permit("R8 no flag", 13'h0000, 1'b0);

    spi_xfer(8'h06, 8'h00, 8'h00, 1, 4, q1, q2);
    rd_status(s);
    check("R10 partial byte", s, 8'h08);

    cmd1(8'h06);
    wr_status(8'h00);
    rd_status(s);
    check("R5 accepted write clears flag", s, 8'h00);
    cmd1(8'h06);
    check_permit("R8 region none top", 13'h1FFF, 1'b1);

    wr_status(8'h04);
    cmd1(8'h06);
    check_permit("R8 quarter below", 13'h17FF, 1'b1);
    check_permit("R8 quarter edge", 13'h1800, 1'b0);

    wr_status(8'h0C);
    cmd1(8'h06);
    rd_status(s);
    check("R6 region all", s, 8'h0E);
    check_permit("R8 all low", 13'h0000, 1'b0);
    check_permit("R8 all high", 13'h1FFF, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule